// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block keeps the exception bookkeeping for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every stage register carries a small record for the instruction it holds: a valid flag, a trap marker, the instruction's PC and a fault vector. A fault pulse from the logic of one stage does not stop the pipeline. It sets one bit in the vector of the instruction that is in that stage, and the instruction keeps flowing.

An instruction with any vector bit set loses its right to change architectural state. Its store in the memory stage and its register write in writeback are both blocked. The vector is examined only when the instruction reaches writeback. At that point the oldest faulting instruction in the pipeline raises a single exception. The block reports the earliest-stage cause, saves the PC for restart, empties every younger stage and puts a trap instruction into fetch. The sources of the faults are plain input pulses. Handler software is not part of the block.

Top module: `exc_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `exc_taken`, `trap_fetch`, `retire_valid`, `mem_store_en` and `wb_reg_en` are 0 and `exc_pc` is 0.
- R2: Instructions without faults leave writeback one per cycle, in fetch order. Each one raises `retire_valid` with its PC on `retire_pc`, raises `wb_reg_en` when `wb_reg_req` is high, and earlier raised `mem_store_en` in its memory cycle when `mem_store_req` was high.
- R3: A fault pulse is never acted on in the stage that raises it. The exception is reported as a pulse of exactly one cycle on `exc_taken`, in the cycle after the faulting instruction occupies writeback.
- R4: Cause codes are fetch fault = 0, undefined opcode = 1, arithmetic overflow = 2, data access fault = 3. When an instruction carries several faults, `exc_cause` gives the one from the earliest stage.
- R5: Exceptions are reported in program order. An older instruction's fault is reported even when a younger instruction raised its own fault earlier in time.
- R6: A faulting instruction never asserts `wb_reg_en` or `mem_store_en`. This includes a data access fault raised in the same cycle as its store request.
- R7: While a faulting instruction is in writeback, the younger instruction in the memory stage gets no `mem_store_en`.
- R8: When an exception is taken, fetch, decode, execute and memory are flushed in that same cycle. No flushed instruction retires. Faults raised in that cycle for those younger instructions are discarded, so only one exception results.
- R9: The cycle in which `exc_taken` is high, the fetch stage holds a trap instruction (`trap_fetch` = 1) with PC `TRAP_PC`. The trap instruction then flows down the pipeline and retires like any other instruction.
- R10: `exc_pc` gives the PC of the faulting instruction from the cycle of `exc_taken` onward. It holds that value until the next exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A new instruction enters fetch at this edge |
| fetch_pc | input | PC_W | PC of the new instruction |
| flt_fetch | input | 1 | Fetch fault on the instruction now in fetch |
| flt_decode | input | 1 | Undefined opcode on the instruction now in decode |
| flt_exec | input | 1 | Arithmetic overflow on the instruction now in execute |
| flt_mem | input | 1 | Data access fault on the instruction now in memory |
| mem_store_req | input | 1 | The instruction in memory wants to store |
| wb_reg_req | input | 1 | The instruction in writeback wants to write a register |
| mem_store_en | output | 1 | Store permitted this cycle |
| wb_reg_en | output | 1 | Register write permitted this cycle |
| retire_valid | output | 1 | A fault-free instruction completes writeback |
| retire_pc | output | PC_W | PC of the retiring instruction |
| exc_taken | output | 1 | One-cycle exception pulse |
| exc_cause | output | 2 | Cause code of the exception taken |
| exc_pc | output | PC_W | Saved PC of the faulting instruction |
| trap_fetch | output | 1 | The fetch stage holds the trap instruction |

## Verification
An instruction fetched at edge n is in fetch after that edge and reaches writeback four edges later. `retire_valid` and `retire_pc` are therefore visible after edge n+4, while `exc_taken`, `exc_cause`, `exc_pc` and `trap_fetch` become visible one edge after that, from registers. The store and register-write enables are combinational on the current stage contents and on that cycle's fault and request inputs. The bench drives each cycle's inputs at the falling edge, reads the registered results right before it drives, and reads the two enables a short delay after it drives, so each value is taken in the cycle it governs. Fault pulses are placed in the exact cycle in which the target instruction occupies the named stage, and the cycles in which faults overlap are computed from those positions.

// File: rtl/exc_pkg.sv
package exc_pkg;

    parameter int unsigned PC_W    = 32;
    parameter int unsigned N_STAGE = 5;
    parameter int unsigned N_CAUSE = 4;

    localparam int unsigned CAUSE_W = $clog2(N_CAUSE);
    localparam int unsigned WB_IDX  = N_STAGE - 1;
    localparam int unsigned MEM_IDX = N_STAGE - 2;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_FETCH  = 2'd0,
        CAUSE_DECODE = 2'd1,
        CAUSE_OVF    = 2'd2,
        CAUSE_DATA   = 2'd3
    } cause_e;

    typedef logic [N_CAUSE-1:0] fault_vec_t;

    typedef struct packed {
        logic             valid;
        logic             trap;
        logic [PC_W-1:0]  pc;
        fault_vec_t       vec;
    } slot_t;

    // earliest-stage fault wins
    function automatic logic [CAUSE_W-1:0] first_cause(fault_vec_t v);
        logic [CAUSE_W-1:0] c;
        c = '0;
        for (int i = int'(N_CAUSE) - 1; i >= 0; i--) begin
            if (v[i]) c = CAUSE_W'(i);
        end
        return c;
    endfunction

    function automatic logic clean(slot_t s);
        return s.valid && (s.vec == '0);
    endfunction

endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
#(
    parameter int unsigned STAGE = 0,
    parameter bit          POSTS = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  fault,
    input  slot_t d_slot,
    output slot_t q_slot,
    output slot_t eff_slot
);

    localparam int unsigned BIT = (STAGE < N_CAUSE) ? STAGE : 0;

    always_ff @(posedge clk) begin
        if (rst || flush) q_slot <= '0;
        else              q_slot <= d_slot;
    end

    // a fault pulse lands in the vector of the instruction held here
    always_comb begin
        eff_slot = q_slot;
        if (POSTS && fault && q_slot.valid) eff_slot.vec[BIT] = 1'b1;
    end

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !q_slot.valid);

endmodule

// File: rtl/exc_resolve.sv
module exc_resolve
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  slot_t              wb_slot,
    output logic               take,
    output logic               exc_taken,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [PC_W-1:0]    exc_pc,
    output logic               retire_valid,
    output logic [PC_W-1:0]    retire_pc
);

    assign take         = wb_slot.valid && (wb_slot.vec != '0);
    assign retire_valid = clean(wb_slot);
    assign retire_pc    = wb_slot.pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_taken <= 1'b0;
            exc_cause <= '0;
            exc_pc    <= '0;
        end else begin
            exc_taken <= take;
            if (take) begin
                exc_cause <= first_cause(wb_slot.vec);
                exc_pc    <= wb_slot.pc;
            end
        end
    end

    fault_vec_t sel_bit, lower_bits;
    assign sel_bit    = fault_vec_t'(1) << exc_cause;
    assign lower_bits = sel_bit - fault_vec_t'(1);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        exc_taken |=> !exc_taken);

    assert_earliest_cause_R4: assert property (@(posedge clk) disable iff (rst)
        exc_taken |-> ((($past(wb_slot.vec) & sel_bit) != '0) &&
                       (($past(wb_slot.vec) & lower_bits) == '0)));

    assert_epc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !exc_taken |-> (exc_pc == $past(exc_pc)));

endmodule

// File: rtl/exc_write_gate.sv
module exc_write_gate
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t mem_slot,
    input  slot_t wb_slot,
    input  logic  take,
    input  logic  store_req,
    input  logic  reg_req,
    output logic  mem_store_en,
    output logic  wb_reg_en
);

    // older faulting instruction in writeback also blocks the store behind it
    assign mem_store_en = clean(mem_slot) && store_req && !take;
    assign wb_reg_en    = clean(wb_slot) && reg_req;

    assert_store_behind_fault_R7: assert property (@(posedge clk) disable iff (rst)
        take |-> !mem_store_en);

    assert_no_faulty_write_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_slot.vec != '0 || wb_slot.vec != '0) |->
            !((mem_slot.vec != '0) && mem_store_en) && !((wb_slot.vec != '0) && wb_reg_en));

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
    import exc_pkg::*;
#(
    parameter logic [PC_W-1:0] TRAP_PC = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_valid,
    input  logic [PC_W-1:0]    fetch_pc,
    input  logic               flt_fetch,
    input  logic               flt_decode,
    input  logic               flt_exec,
    input  logic               flt_mem,
    input  logic               mem_store_req,
    input  logic               wb_reg_req,
    output logic               mem_store_en,
    output logic               wb_reg_en,
    output logic               retire_valid,
    output logic [PC_W-1:0]    retire_pc,
    output logic               exc_taken,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [PC_W-1:0]    exc_pc,
    output logic               trap_fetch
);

    slot_t               q_s   [N_STAGE];
    slot_t               eff_s [N_STAGE];
    slot_t               din_s [N_STAGE];
    slot_t               fetch_slot;
    slot_t               trap_slot;
    logic [N_STAGE-1:0]  flt;
    logic                take;

    assign flt = {1'b0, flt_mem, flt_exec, flt_decode, flt_fetch};

    always_comb begin
        fetch_slot       = '0;
        fetch_slot.valid = fetch_valid;
        fetch_slot.pc    = fetch_pc;
        trap_slot        = '0;
        trap_slot.valid  = 1'b1;
        trap_slot.trap   = 1'b1;
        trap_slot.pc     = TRAP_PC;
    end

    for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign din_s[k] = take ? trap_slot : fetch_slot;
        end else begin : g_body
            assign din_s[k] = eff_s[k-1];
        end

        exc_stage_reg #(
            .STAGE (k),
            .POSTS (k < N_CAUSE)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .flush    ((k == 0) ? 1'b0 : take),
            .fault    (flt[k]),
            .d_slot   (din_s[k]),
            .q_slot   (q_s[k]),
            .eff_slot (eff_s[k])
        );
    end

    exc_resolve u_resolve (
        .clk          (clk),
        .rst          (rst),
        .wb_slot      (eff_s[WB_IDX]),
        .take         (take),
        .exc_taken    (exc_taken),
        .exc_cause    (exc_cause),
        .exc_pc       (exc_pc),
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc)
    );

    exc_write_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .mem_slot     (eff_s[MEM_IDX]),
        .wb_slot      (eff_s[WB_IDX]),
        .take         (take),
        .store_req    (mem_store_req),
        .reg_req      (wb_reg_req),
        .mem_store_en (mem_store_en),
        .wb_reg_en    (wb_reg_en)
    );

    assign trap_fetch = q_s[0].valid && q_s[0].trap;

    assert_trap_follows_R9: assert property (@(posedge clk) disable iff (rst)
        exc_taken |-> (trap_fetch && q_s[0].pc == TRAP_PC));

    assert_flushed_no_retire_R8: assert property (@(posedge clk) disable iff (rst)
        exc_taken |-> !retire_valid);

endmodule

// File: tb/exc_tracker_bench.sv
`timescale 1ns/1ps
module exc_tracker_bench;
    import exc_pkg::*;

    localparam logic [31:0] TRAP = 32'h0000_0080;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               fetch_valid = 1'b0;
    logic [PC_W-1:0]    fetch_pc = '0;
    logic               flt_fetch = 1'b0, flt_decode = 1'b0, flt_exec = 1'b0, flt_mem = 1'b0;
    logic               mem_store_req = 1'b1, wb_reg_req = 1'b1;
    logic               mem_store_en, wb_reg_en, retire_valid, exc_taken, trap_fetch;
    logic [PC_W-1:0]    retire_pc, exc_pc;
    logic [CAUSE_W-1:0] exc_cause;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] plan [0:7];

    always #2.5 clk = ~clk;

    exc_tracker #(.TRAP_PC(TRAP)) u_exc_tracker (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .flt_fetch(flt_fetch), .flt_decode(flt_decode), .flt_exec(flt_exec), .flt_mem(flt_mem),
        .mem_store_req(mem_store_req), .wb_reg_req(wb_reg_req),
        .mem_store_en(mem_store_en), .wb_reg_en(wb_reg_en),
        .retire_valid(retire_valid), .retire_pc(retire_pc),
        .exc_taken(exc_taken), .exc_cause(exc_cause), .exc_pc(exc_pc), .trap_fetch(trap_fetch)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic planned(int t, int k, int n);
        int idx;
        idx = t - 1 - k;
        if (idx < 0 || idx >= n) return 1'b0;
        return plan[idx][k];
    endfunction

    task automatic clear_plan();
        for (int i = 0; i < 8; i++) plan[i] = 4'b0000;
    endtask

    // Streams n instructions; instruction i is fetched in interval i and is in stage k during interval i+1+k.
    task automatic run_stream(input string tag, input int n, input logic [31:0] base,
                              input int exp_exc, input int exp_cause, input logic [31:0] exp_pc,
                              input int exp_ret, input logic [31:0] exp_last,
                              input int exp_st, input int exp_rw, input logic [31:0] exp_hold);
        int n_exc = 0, n_ret = 0, n_st = 0, n_rw = 0, ord_err = 0;
        int cause_seen = 0, trap_seen = 0;
        logic [31:0] pc_seen = '0, last = '0, nxt;
        logic stopped = 1'b0;
        nxt = base;
        for (int t = 0; t < n + 14; t++) begin
            @(negedge clk);
            if (exc_taken) begin
                n_exc++;
                if (n_exc == 1) begin
                    cause_seen = int'(exc_cause);
                    pc_seen    = exc_pc;
                    trap_seen  = int'(trap_fetch);
                end
                stopped = 1'b1;
            end
            if (retire_valid) begin
                n_ret++;
                last = retire_pc;
                if (retire_pc != TRAP) begin
                    if (retire_pc != nxt) ord_err++;
                    nxt = retire_pc + 32'd4;
                end
            end
            fetch_valid = (t < n) && !stopped;
            fetch_pc    = base + 32'(4 * t);
            flt_fetch   = !stopped && planned(t, 0, n);
            flt_decode  = !stopped && planned(t, 1, n);
            flt_exec    = !stopped && planned(t, 2, n);
            flt_mem     = !stopped && planned(t, 3, n);
            #1;
            if (mem_store_en) n_st++;
            if (wb_reg_en)    n_rw++;
        end
        fetch_valid = 1'b0;
        chk("R3/R8", {tag, " exception pulses"}, n_exc, exp_exc);
        if (exp_exc != 0) begin
            chk("R4", {tag, " cause"}, cause_seen, exp_cause);
            chk("R5/R10", {tag, " saved pc"}, pc_seen, exp_pc);
            chk("R9", {tag, " trap in fetch with pulse"}, trap_seen, 1);
        end
        chk("R2/R8", {tag, " retire count"}, n_ret, exp_ret);
        chk("R2/R9", {tag, " last retired pc"}, last, exp_last);
        chk("R2", {tag, " retire order"}, ord_err, 0);
        chk("R6/R7", {tag, " stores"}, n_st, exp_st);
        chk("R6", {tag, " register writes"}, n_rw, exp_rw);
        chk("R10", {tag, " pc held"}, exc_pc, exp_hold);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "taken in reset", exc_taken, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "taken", exc_taken, 0);
        chk("R1", "trap", trap_fetch, 0);
        chk("R1", "retire", retire_valid, 0);
        chk("R1", "store", mem_store_en, 0);
        chk("R1", "regwrite", wb_reg_en, 0);
        chk("R1", "pc", exc_pc, 0);
    endtask

    task automatic t_clean();
        clear_plan();
        run_stream("R2 clean", 5, 32'h1000, 0, 0, 0, 5, 32'h1010, 5, 5, 32'h0);
    endtask

    task automatic t_overflow();
        clear_plan();
        plan[2] = 4'b0100;
        run_stream("R3 overflow", 6, 32'h100, 1, 2, 32'h108, 3, TRAP, 3, 3, 32'h108);
    endtask

    task automatic t_multi();
        clear_plan();
        plan[1] = 4'b1010;
        run_stream("R4 multi", 4, 32'h200, 1, 1, 32'h204, 2, TRAP, 2, 2, 32'h204);
    endtask

    task automatic t_order();
        clear_plan();
        plan[2] = 4'b1000;
        plan[3] = 4'b0001;
        run_stream("R5 order", 6, 32'h300, 1, 3, 32'h308, 3, TRAP, 3, 3, 32'h308);
    endtask

    task automatic t_flush_faults();
        clear_plan();
        plan[1] = 4'b0100;
        plan[2] = 4'b1000;
        plan[3] = 4'b0100;
        run_stream("R8 flush", 6, 32'h400, 1, 2, 32'h404, 2, TRAP, 2, 2, 32'h404);
    endtask

    task automatic t_fetch_fault();
        clear_plan();
        plan[0] = 4'b0001;
        run_stream("R4 fetch", 3, 32'h500, 1, 0, 32'h500, 1, TRAP, 1, 1, 32'h500);
    endtask

    task automatic t_hold();
        clear_plan();
        run_stream("R10 hold", 3, 32'h600, 0, 0, 0, 3, 32'h608, 3, 3, 32'h500);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_clean();
        t_overflow();
        t_multi();
        t_order();
        t_flush_faults();
        t_fetch_fault();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule